// File: doc/BRIEF.md
# Debug Translation Probe for an I/O MMU

This block gives software a register window for asking the address translation engine of an I/O memory management unit to translate one I/O virtual address on demand. Software loads the virtual address into one register. It then writes a control word that carries the device number, the process number, a read-only flag and a start bit.

A control write with the start bit set marks the block busy and presents one request to the translation engine over a valid/ready channel. The request holds its payload until the engine accepts it. The engine later returns a single-cycle result. The block turns that result into a response word and drops busy on the same clock edge. Software polls the start/busy bit to learn when the response can be read.

The response word has two layouts, chosen by bit 0. When bit 0 is 1, the word reports a fault and carries a 10-bit cause code starting at bit 10. When bit 0 is 0, the word carries the 4 KiB page number of the translated address in bits 53:10. The size flag in bit 9 is always 0, because the block never reports superpages.

Back-pressure rules:
- `req_valid` stays high with a constant payload until a cycle in which `req_ready` is also high.
- The result channel has no ready signal. A result pulse is consumed in the one cycle it is presented, and only while the block is waiting for a result.

Top module: `xlt_probe_port`

## Requirements
- R1: After reset the capability register at offset 0x000 reads exactly 0x0000_0000_8000_0000 (bit 31 set, all other bits 0). The virtual-address register (0x258), the control register (0x260) and the response register (0x268) all read 0, and `req_valid` is 0.
- R2: While not busy, a write to offset 0x258 stores all 64 bits, and reading 0x258 returns them.
- R3: While not busy, a write to 0x260 with bit 0 set marks the block busy, so 0x260 reads back with bit 0 = 1. It then raises `req_valid` with these values:
  - `req_iova` equal to the stored virtual address;
  - `req_dev` taken from bits 63:40 of the write;
  - `req_proc` taken from bits 31:12 of the write.
- R4: While not busy, a write to 0x260 with bit 0 clear stores the fields (bit 3, bits 31:12, bits 63:40), with every other bit reading 0. It raises no request and leaves the response register unchanged.
- R5: `req_write` is 1 (read-write permission) when control bit 3 is 0, and 0 (read-only) when bit 3 is 1.
- R6: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1 and `req_iova`, `req_dev`, `req_proc` and `req_write` stay unchanged on the next cycle.
- R7: A result with `rsp_no_ctx` = 1 writes a response with bit 0 = 1 and bits 19:10 = 256, with all other bits 0. This takes priority over `rsp_fault`.
- R8: A result with `rsp_no_ctx` = 0 and `rsp_fault` = 1 writes a response with bit 0 = 1, `rsp_cause` in bits 19:10, and all other bits 0.
- R9: A successful result writes bits 53:10 = `rsp_paddr[55:12]`, with bits 9:0 and 63:54 all 0.
- R10: The clock edge that writes the response also clears busy. At that point 0x260 bit 0 reads 0, and the new response is readable.
- R11: While busy, writes to 0x258 and 0x260 are ignored. The stored address, the control fields and the response are unchanged, and no additional request is issued.
- R12: Each start produces exactly one request handshake. `req_valid` is 0 on the cycle after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wen | input | 1 | Register write strobe |
| csr_addr | input | 12 | Register byte offset for reads and writes |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Read data for `csr_addr` (combinational) |
| req_valid | output | 1 | Translation request valid |
| req_ready | input | 1 | Engine accepts the request |
| req_iova | output | 64 | Virtual address to translate |
| req_dev | output | 24 | Device number |
| req_proc | output | 20 | Process number |
| req_write | output | 1 | 1 = read-write permission, 0 = read-only |
| rsp_valid | input | 1 | Result pulse (single cycle) |
| rsp_no_ctx | input | 1 | No valid context for the device/process pair |
| rsp_fault | input | 1 | Translation faulted |
| rsp_cause | input | 10 | Fault cause code |
| rsp_paddr | input | 56 | Translated physical address |

## Verification
The hardest situation to reach from the ports is register traffic that lands while a translation is in flight. The request and result each take only a few cycles, so writes during that window would normally be rare. The bench's engine stub holds `req_ready` low for several cycles and delays the result pulse, which keeps the block busy long enough for the test to issue address and control writes, including one that sets the start bit. After the result arrives, the test confirms that the stored address, the response contents and the absence of a second request all reflect only the original command.

// File: rtl/xlt_probe_pkg.sv
package xlt_probe_pkg;
  localparam int CSR_AW  = 12;
  localparam int WORD_W  = 64;
  localparam int DEV_W   = 24;
  localparam int PROC_W  = 20;
  localparam int PAGE_SH = 12;
  localparam int PPN_LSB = 10;
  localparam int PPN_W   = 44;

  localparam logic [CSR_AW-1:0] OFS_CAP  = 12'h000;
  localparam logic [CSR_AW-1:0] OFS_IOVA = 12'h258;
  localparam logic [CSR_AW-1:0] OFS_CTL  = 12'h260;
  localparam logic [CSR_AW-1:0] OFS_RESP = 12'h268;

  localparam int CTL_GO  = 0;
  localparam int CTL_NW  = 3;
  localparam int CAP_DBG = 31;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [DEV_W-1:0]  dev;
    logic [PROC_W-1:0] proc;
    logic              nw;
  } ctl_fields_t;
endpackage

// File: rtl/xlt_probe_regs.sv
module xlt_probe_regs
  import xlt_probe_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_wen,
  input  logic [CSR_AW-1:0]   csr_addr,
  input  logic [WORD_W-1:0]   csr_wdata,
  output logic [WORD_W-1:0]   csr_rdata,
  input  logic                busy,
  input  logic [WORD_W-1:0]   resp_word,
  output logic [WORD_W-1:0]   iova_q,
  output ctl_fields_t         ctl_q,
  output logic                go_pulse
);
  localparam logic [WORD_W-1:0] CAP_VALUE = WORD_W'(1) << CAP_DBG;

  logic wr_open;
  logic wr_iova;
  logic wr_ctl;

  assign wr_open  = csr_wen && !busy;
  assign wr_iova  = wr_open && (csr_addr == OFS_IOVA);
  assign wr_ctl   = wr_open && (csr_addr == OFS_CTL);
  assign go_pulse = wr_ctl && csr_wdata[CTL_GO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iova_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (wr_iova) iova_q <= csr_wdata;
      if (wr_ctl) begin
        ctl_q.nw   <= csr_wdata[CTL_NW];
        ctl_q.proc <= csr_wdata[31:12];
        ctl_q.dev  <= csr_wdata[63:40];
      end
    end
  end

  always_comb begin
    unique case (csr_addr)
      OFS_CAP:  csr_rdata = CAP_VALUE;
      OFS_IOVA: csr_rdata = iova_q;
      OFS_CTL:  csr_rdata = {ctl_q.dev, 8'b0, ctl_q.proc, 8'b0, ctl_q.nw, 2'b0, busy};
      OFS_RESP: csr_rdata = resp_word;
      default:  csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xlt_probe_seq.sv
module xlt_probe_seq
  import xlt_probe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_pulse,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic req_valid,
  output logic busy,
  output logic rsp_take
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (go_pulse)  state_d = SQ_REQ;
      SQ_REQ:  if (req_ready) state_d = SQ_WAIT;
      SQ_WAIT: if (rsp_valid) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  assign req_valid = (state_q == SQ_REQ);
  assign busy      = (state_q != SQ_IDLE);
  assign rsp_take  = (state_q == SQ_WAIT) && rsp_valid;
endmodule

// File: rtl/xlt_probe_fmt.sv
module xlt_probe_fmt
  import xlt_probe_pkg::*;
#(
  parameter int PA_W        = 56,
  parameter int CAUSE_W     = 10,
  parameter int NOCTX_CAUSE = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rsp_take,
  input  logic               rsp_no_ctx,
  input  logic               rsp_fault,
  input  logic [CAUSE_W-1:0] rsp_cause,
  input  logic [PA_W-1:0]    rsp_paddr,
  output logic [WORD_W-1:0]  resp_q
);
  localparam int SRC_PPN_W = PA_W - PAGE_SH;
  localparam logic [CAUSE_W-1:0] NOCTX_CODE = CAUSE_W'(NOCTX_CAUSE);

  logic [PPN_W-1:0]  ppn;
  logic [WORD_W-1:0] word_d;

  generate
    if (SRC_PPN_W >= PPN_W) begin : g_ppn_trunc
      assign ppn = rsp_paddr[PAGE_SH +: PPN_W];
    end else begin : g_ppn_ext
      assign ppn = {{(PPN_W-SRC_PPN_W){1'b0}}, rsp_paddr[PA_W-1:PAGE_SH]};
    end
  endgenerate

  always_comb begin
    word_d = '0;
    if (rsp_no_ctx) begin
      word_d[0] = 1'b1;
      word_d[PPN_LSB +: CAUSE_W] = NOCTX_CODE;
    end else if (rsp_fault) begin
      word_d[0] = 1'b1;
      word_d[PPN_LSB +: CAUSE_W] = rsp_cause;
    end else begin
      word_d[PPN_LSB +: PPN_W] = ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        resp_q <= '0;
    else if (rsp_take) resp_q <= word_d;
  end
endmodule

// File: rtl/xlt_probe_port.sv
module xlt_probe_port
  import xlt_probe_pkg::*;
#(
  parameter int PA_W        = 56,
  parameter int CAUSE_W     = 10,
  parameter int NOCTX_CAUSE = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_wen,
  input  logic [11:0]        csr_addr,
  input  logic [63:0]        csr_wdata,
  output logic [63:0]        csr_rdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [63:0]        req_iova,
  output logic [23:0]        req_dev,
  output logic [19:0]        req_proc,
  output logic               req_write,
  input  logic               rsp_valid,
  input  logic               rsp_no_ctx,
  input  logic               rsp_fault,
  input  logic [CAUSE_W-1:0] rsp_cause,
  input  logic [PA_W-1:0]    rsp_paddr
);
  logic              busy;
  logic              go_pulse;
  logic              rsp_take;
  logic [WORD_W-1:0] iova_q;
  logic [WORD_W-1:0] resp_q;
  ctl_fields_t       ctl_q;

  xlt_probe_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wen   (csr_wen),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .busy      (busy),
    .resp_word (resp_q),
    .iova_q    (iova_q),
    .ctl_q     (ctl_q),
    .go_pulse  (go_pulse)
  );

  xlt_probe_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_pulse  (go_pulse),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .req_valid (req_valid),
    .busy      (busy),
    .rsp_take  (rsp_take)
  );

  xlt_probe_fmt #(
    .PA_W        (PA_W),
    .CAUSE_W     (CAUSE_W),
    .NOCTX_CAUSE (NOCTX_CAUSE)
  ) u_fmt (
    .clk        (clk),
    .rst_n      (rst_n),
    .rsp_take   (rsp_take),
    .rsp_no_ctx (rsp_no_ctx),
    .rsp_fault  (rsp_fault),
    .rsp_cause  (rsp_cause),
    .rsp_paddr  (rsp_paddr),
    .resp_q     (resp_q)
  );

  assign req_iova  = iova_q;
  assign req_dev   = ctl_q.dev;
  assign req_proc  = ctl_q.proc;
  assign req_write = !ctl_q.nw;
endmodule

// File: rtl/xlt_probe_chk.sv
module xlt_probe_chk #(
  parameter int CAUSE_W     = 10,
  parameter int NOCTX_CAUSE = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_iova,
  input logic [23:0] req_dev,
  input logic [19:0] req_proc,
  input logic        req_write,
  input logic        busy,
  input logic        rsp_take,
  input logic        rsp_no_ctx,
  input logic        rsp_fault,
  input logic [63:0] resp_q,
  input logic        csr_wen,
  input logic [11:0] csr_addr,
  input logic [63:0] iova_q
);
  assert_hold_payload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_iova) && $stable(req_dev)
                                   && $stable(req_proc) && $stable(req_write)));

  assert_single_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  assert_request_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

  assert_busy_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> !busy);

  assert_noctx_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && rsp_no_ctx) |=> (resp_q[0] && resp_q[10 +: CAUSE_W] == CAUSE_W'(NOCTX_CAUSE)));

  assert_success_low_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && !rsp_no_ctx && !rsp_fault) |=> (resp_q[9:0] == 10'd0));

  assert_iova_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && csr_wen && csr_addr == 12'h258) |=> $stable(iova_q));
endmodule

bind xlt_probe_port xlt_probe_chk #(
  .CAUSE_W     (CAUSE_W),
  .NOCTX_CAUSE (NOCTX_CAUSE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_iova   (req_iova),
  .req_dev    (req_dev),
  .req_proc   (req_proc),
  .req_write  (req_write),
  .busy       (busy),
  .rsp_take   (rsp_take),
  .rsp_no_ctx (rsp_no_ctx),
  .rsp_fault  (rsp_fault),
  .resp_q     (resp_q),
  .csr_wen    (csr_wen),
  .csr_addr   (csr_addr),
  .iova_q     (iova_q)
);

// File: tb/xlt_probe_port_test.sv
`timescale 1ns/1ps
module xlt_probe_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wen = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [63:0] req_iova;
  logic [23:0] req_dev;
  logic [19:0] req_proc;
  logic        req_write;
  logic        rsp_valid = 1'b0;
  logic        rsp_no_ctx = 1'b0;
  logic        rsp_fault = 1'b0;
  logic [9:0]  rsp_cause = '0;
  logic [55:0] rsp_paddr = '0;

  int n_checks = 0;
  int n_fails  = 0;

  logic [63:0] got_iova;
  logic [23:0] got_dev;
  logic [19:0] got_proc;
  logic        got_write;
  logic        hold_ok;

  always #4 clk = ~clk;

  xlt_probe_port uut (
    .clk(clk), .rst_n(rst_n), .csr_wen(csr_wen), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_iova(req_iova), .req_dev(req_dev),
    .req_proc(req_proc), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_no_ctx(rsp_no_ctx), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_paddr(rsp_paddr)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_wen = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wen = 1'b0;
  endtask

  task automatic csr_read(input logic [11:0] a, output logic [63:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  function automatic logic [63:0] ctl_word(input logic [23:0] dev, input logic [19:0] proc,
                                           input logic nw, input logic go);
    return {dev, 8'hA5, proc, 8'h5A, nw, 2'b11, go};
  endfunction

  // Engine stub: hold ready low for dly cycles, then accept.
  task automatic engine_accept(input int dly);
    hold_ok = 1'b1;
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      if (!req_valid || req_iova !== got_iova || req_dev !== got_dev ||
          req_proc !== got_proc || req_write !== got_write) hold_ok = 1'b0;
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic engine_reply(input int dly, input logic nc, input logic flt,
                              input logic [9:0] cause, input logic [55:0] pa);
    for (int i = 0; i < dly; i++) @(negedge clk);
    rsp_valid = 1'b1; rsp_no_ctx = nc; rsp_fault = flt; rsp_cause = cause; rsp_paddr = pa;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_no_ctx = 1'b0; rsp_fault = 1'b0;
  endtask

  task automatic launch(input logic [63:0] va, input logic [23:0] dev,
                        input logic [19:0] proc, input logic nw, input string tag);
    logic [63:0] rd;
    csr_write(12'h258, va);
    csr_write(12'h260, ctl_word(dev, proc, nw, 1'b1));
    got_iova = req_iova; got_dev = req_dev; got_proc = req_proc; got_write = req_write;
    check({tag, " R3 req_valid"}, {63'd0, req_valid}, 64'd1);
    check({tag, " R3 iova"}, req_iova, va);
    check({tag, " R3 dev"}, {40'd0, req_dev}, {40'd0, dev});
    check({tag, " R3 proc"}, {44'd0, req_proc}, {44'd0, proc});
    check({tag, " R5 permission"}, {63'd0, req_write}, {63'd0, !nw});
    csr_read(12'h260, rd);
    check({tag, " R3 busy readback"}, {63'd0, rd[0]}, 64'd1);
  endtask

  task automatic finish_and_check(input string tag, input logic [63:0] exp_resp);
    logic [63:0] rd;
    csr_read(12'h260, rd);
    check({tag, " R10 busy cleared"}, {63'd0, rd[0]}, 64'd0);
    csr_read(12'h268, rd);
    check({tag, " response"}, rd, exp_resp);
    check({tag, " R12 no second request"}, {63'd0, req_valid}, 64'd0);
    @(negedge clk);
    check({tag, " R12 still idle"}, {63'd0, req_valid}, 64'd0);
  endtask

  task automatic t_reset();
    logic [63:0] rd;
    csr_read(12'h000, rd); check("R1 capability", rd, 64'h0000_0000_8000_0000);
    csr_read(12'h258, rd); check("R1 iova reset", rd, 64'd0);
    csr_read(12'h260, rd); check("R1 ctl reset", rd, 64'd0);
    csr_read(12'h268, rd); check("R1 resp reset", rd, 64'd0);
    check("R1 req_valid reset", {63'd0, req_valid}, 64'd0);
  endtask

  task automatic t_iova_rw();
    logic [63:0] rd;
    csr_write(12'h258, 64'hFEDC_BA98_7654_3210);
    csr_read(12'h258, rd);
    check("R2 iova readback", rd, 64'hFEDC_BA98_7654_3210);
  endtask

  task automatic t_go_clear();
    logic [63:0] rd;
    csr_write(12'h260, ctl_word(24'hABCDEF, 20'h12345, 1'b1, 1'b0));
    csr_read(12'h260, rd);
    check("R4 ctl fields stored", rd, {24'hABCDEF, 8'h00, 20'h12345, 8'h00, 1'b1, 2'b00, 1'b0});
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R4 no request", {63'd0, req_valid}, 64'd0);
    end
    csr_read(12'h268, rd);
    check("R4 response untouched", rd, 64'd0);
  endtask

  task automatic t_success_rw();
    launch(64'h0000_7FFF_1234_5000, 24'h000123, 20'h00042, 1'b0, "succ_rw");
    engine_accept(3);
    check("R6 payload held during back-pressure", {63'd0, hold_ok}, 64'd1);
    engine_reply(2, 1'b0, 1'b0, 10'd0, 56'hAB_CDEF_0123_4FFF);
    finish_and_check("succ_rw R9", {10'd0, 44'hAB_CDEF_0123_4, 10'd0});
  endtask

  task automatic t_success_ro();
    launch(64'h1111_2222_3333_4444, 24'hFFFFFF, 20'hFFFFF, 1'b1, "succ_ro");
    engine_accept(0);
    engine_reply(0, 1'b0, 1'b0, 10'h3FF, 56'hFF_FFFF_FFFF_FFFF);
    finish_and_check("succ_ro R9", {10'd0, {44{1'b1}}, 10'd0});
  endtask

  task automatic t_noctx();
    launch(64'h0000_0000_0000_1000, 24'h000007, 20'h00001, 1'b0, "noctx");
    engine_accept(1);
    engine_reply(1, 1'b1, 1'b1, 10'h155, 56'h12_3456_789A_BCDE);
    finish_and_check("noctx R7", 64'h0000_0000_0004_0001);
  endtask

  task automatic t_fault();
    launch(64'h0000_0000_DEAD_B000, 24'h00BEEF, 20'h0CAFE, 1'b1, "fault");
    engine_accept(2);
    engine_reply(3, 1'b0, 1'b1, 10'h2A5, 56'h77_7777_7777_7777);
    finish_and_check("fault R8", {44'd0, 10'h2A5, 9'd0, 1'b1});
  endtask

  task automatic t_busy_writes();
    logic [63:0] rd;
    launch(64'h0000_0ABC_0000_0000, 24'h000321, 20'h00777, 1'b0, "busy");
    csr_write(12'h258, 64'h5555_5555_5555_5555);
    csr_write(12'h260, ctl_word(24'h999999, 20'h88888, 1'b1, 1'b1));
    engine_accept(2);
    check("R11 payload unchanged by writes", {63'd0, hold_ok}, 64'd1);
    csr_write(12'h260, ctl_word(24'h111111, 20'h22222, 1'b1, 1'b1));
    engine_reply(1, 1'b0, 1'b1, 10'h001, 56'd0);
    finish_and_check("busy R8", {44'd0, 10'h001, 9'd0, 1'b1});
    csr_read(12'h258, rd);
    check("R11 iova unchanged", rd, 64'h0000_0ABC_0000_0000);
    csr_read(12'h260, rd);
    check("R11 ctl unchanged", rd, {24'h000321, 8'h00, 20'h00777, 8'h00, 1'b0, 2'b00, 1'b0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_iova_rw();
    t_go_clear();
    t_success_rw();
    t_success_ro();
    t_noctx();
    t_fault();
    t_busy_writes();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule